// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter. Software sees two small registers. The control register holds the enable, start, continuous-mode, completion-flag and interrupt-enable bits, plus a 3-bit clock-divider select. The mux register holds a 4-bit input channel and a 2-bit reference choice. The block divides the system clock down to the converter clock and steps through the conversion sequence: a sample phase, ten trial bits from MSB to LSB, and two closing clocks. It decides each trial bit from an external comparator that reports whether the analog input is at or above the trial code driven on `dac_code`.

When a result is stored, the completion flag rises and an interrupt request may follow. In continuous mode, one start launches conversions back to back until the mode bit is cleared. The first conversion after the block is enabled runs a longer, initialising sequence. A channel or reference written during a conversion is applied only once that conversion has finished.

Top module: `adc_seq_top`

## Requirements
- R1: The divider select (control bits 7:5) sets the number of system clocks per converter clock: 0 and 1 give 2, and codes 2 to 7 give 4, 8, 16, 32, 64 and 128 (two to the power of the code).
- R2: A conversion started while already enabled lasts 13 converter clocks. The flag reads one and busy reads zero exactly 13×divider system clocks after the clock edge that accepts the start write.
- R3: The first conversion after enable rises lasts 25 converter clocks (25×divider system clocks). This holds when enable and start arrive in one write and when start follows a separate enabling write.
- R4: Control bit 1 (start) reads one while a conversion runs. Writing zero to it changes nothing. A start written while enable (bit 0) stays zero launches nothing.
- R5: `sample_en` is high for the first converter clock of the main sequence. The trial code then sets bits 9 down to 0, one per converter clock. A bit is kept when `cmp_hi` is high, so the stored 10-bit result equals the largest code not above the analog input.
- R6: With continuous mode (bit 2) set, one start produces conversions every 13 converter clocks, each updating the result. Clearing bit 2 lets the running conversion finish and starts no further one.
- R7: Clearing enable during a conversion stops it at once. No result is stored and the flag does not rise.
- R8: The mux register keeps the channel in bits 3:0 (0–7 inputs, 14 bandgap, 15 ground) and the reference in bits 5:4 (0 external, 1 supply, 3 internal, 2 reserved). It reads back at once. `chan_sel`/`ref_sel` follow it on the next clock while idle, but during a conversion they hold until the conversion completes.
- R9: The flag (bit 3) sets when a result is stored. It clears on a written one or on an `irq_ack` pulse. A written zero leaves it unchanged, and a set in the same cycle as a clear leaves it set.
- R10: `irq` is high exactly when the flag, interrupt enable (bit 4) and `gie` are all high.
- R11: After reset both registers read zero, and `irq`, `chan_sel`, `ref_sel` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data |
| mux_wr | input | 1 | Write strobe for the mux register |
| mux_wdata | input | 6 | Mux write data (reference 5:4, channel 3:0) |
| ctrl_rdata | output | 8 | Control readback (divider, ie, flag, continuous, busy, enable) |
| mux_rdata | output | 6 | Mux register readback |
| cmp_hi | input | 1 | Comparator: input at or above the trial code |
| dac_code | output | 10 | Trial code for the external DAC |
| sample_en | output | 1 | Sample phase active |
| chan_sel | output | 4 | Channel applied to the analog mux |
| ref_sel | output | 2 | Reference applied to the converter |
| result | output | 10 | Last stored conversion result |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
The in-line properties watch, on every cycle, the following invariants: converter ticks never come two in a row, the step counter stays within the sequence length, the result moves only on a completion, and the flag rises only because of one. They also check that a running conversion survives a zero written to start, that an abort drops busy at once, and that the applied channel and reference hold still while a conversion runs. Only the scenarios can show the exact cycle counts for each divider and for the first conversion versus later ones. The same holds for the full comparator sweep that yields the right code, the back-to-back spacing in continuous mode, the handover of a deferred channel at the completion edge, and the set-beats-clear race on the flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int PSC_W = 3;
  localparam int RES_W = 10;
  localparam int NORM_LEN = 13;
  localparam int INIT_EXTRA = 12;
  localparam int CHAN_W = 4;
  localparam int REFS_W = 2;

  localparam int B_EN = 0;
  localparam int B_START = 1;
  localparam int B_FREE = 2;
  localparam int B_FLAG = 3;
  localparam int B_IE = 4;
  localparam int B_PSC = 5;

  typedef struct packed {
    logic [REFS_W-1:0] refsel;
    logic [CHAN_W-1:0] chan;
  } mux_t;

  // system clocks per converter clock
  function automatic int unsigned psc_div(input logic [PSC_W-1:0] sel);
    if (sel == '0) return 2;
    return 32'd1 << sel;
  endfunction

  // converter clocks for one conversion
  function automatic int unsigned conv_len(input logic first);
    return first ? (NORM_LEN + INIT_EXTRA) : NORM_LEN;
  endfunction
endpackage

// File: rtl/adc_seq_prescaler.sv
module adc_seq_prescaler
  import adc_seq_pkg::*;
#(
  parameter int SEL_W = PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(psc_div(sel) - 1);
  // >= keeps a mid-count divider change from running the counter around
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || !run)     cnt <= '0;
    else if (tick)                cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar
  import adc_seq_pkg::*;
#(
  parameter int W     = RES_W,
  parameter int LEN_N = NORM_LEN,
  parameter int LEN_X = INIT_EXTRA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic         first,
  input  logic         abort,
  input  logic         tick,
  input  logic         cmp_hi,
  output logic         active,
  output logic         done,
  output logic         sample_en,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] result
);
  localparam int LEN_MAX = LEN_N + LEN_X;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic             long_r;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] off;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] phase;
  logic             in_main;
  logic [W-1:0]     acc;
  logic [W-1:0]     trial_mask;

  assign off     = long_r ? CNT_W'(LEN_X) : '0;
  assign last    = off + CNT_W'(LEN_N - 1);
  assign in_main = active && (cnt >= off);
  assign phase   = cnt - off;

  assign sample_en = in_main && (phase == '0);

  // trial bit b is live in the main-sequence step W-b
  for (genvar b = 0; b < W; b++) begin : g_trial
    assign trial_mask[b] = in_main && (phase == CNT_W'(W - b));
  end

  assign dac_code = acc | trial_mask;
  assign done     = active && tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      long_r <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      result <= '0;
    end else begin
      if (abort) begin
        active <= 1'b0;
      end else if (launch) begin
        active <= 1'b1;
        long_r <= first;
        cnt    <= '0;
        acc    <= '0;
      end else if (done) begin
        active <= 1'b0;
      end else if (active && tick) begin
        cnt <= cnt + 1'b1;
        acc <= acc | (cmp_hi ? trial_mask : '0);
      end
      if (done && !abort) result <= acc;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= CNT_W'(LEN_MAX - 1)));
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(result));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  input  logic              mux_wr,
  input  logic [5:0]        mux_wdata,
  output logic [7:0]        ctrl_rdata,
  output logic [5:0]        mux_rdata,
  input  logic              cmp_hi,
  output logic [RES_W-1:0]  dac_code,
  output logic              sample_en,
  output logic [CHAN_W-1:0] chan_sel,
  output logic [REFS_W-1:0] ref_sel,
  output logic [RES_W-1:0]  result,
  input  logic              gie,
  input  logic              irq_ack,
  output logic              irq
);
  logic             en_q, fr_q, ie_q, flag_q, first_pend;
  logic [PSC_W-1:0] psc_q;
  mux_t             mux_q, mux_next;

  logic busy, cpl, cpl_ok, tick;
  logic w_en, w_start, w_fr, w_flag;
  logic en_rise, start_req, abort, launch, fr_next, first_in, flag_clr;

  assign w_en    = ctrl_wdata[B_EN];
  assign w_start = ctrl_wdata[B_START];
  assign w_fr    = ctrl_wdata[B_FREE];
  assign w_flag  = ctrl_wdata[B_FLAG];

  assign en_rise   = ctrl_wr && w_en && !en_q;
  assign start_req = ctrl_wr && w_en && w_start && !busy;
  assign abort     = ctrl_wr && !w_en && busy;
  assign fr_next   = ctrl_wr ? w_fr : fr_q;
  assign cpl_ok    = cpl && !abort;
  assign launch    = start_req || (cpl_ok && fr_next);
  assign first_in  = first_pend || en_rise;
  assign flag_clr  = (ctrl_wr && w_flag) || irq_ack;
  assign mux_next  = mux_wr ? mux_t'(mux_wdata) : mux_q;

  adc_seq_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(launch),
    .sel(psc_q), .tick(tick)
  );

  adc_seq_sar u_sar (
    .clk(clk), .rst_n(rst_n), .launch(launch), .first(first_in),
    .abort(abort), .tick(tick), .cmp_hi(cmp_hi), .active(busy),
    .done(cpl), .sample_en(sample_en), .dac_code(dac_code), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; fr_q <= 1'b0; ie_q <= 1'b0; psc_q <= '0;
    end else if (ctrl_wr) begin
      en_q  <= w_en;
      fr_q  <= w_fr;
      ie_q  <= ctrl_wdata[B_IE];
      psc_q <= ctrl_wdata[B_PSC +: PSC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      first_pend <= 1'b0;
    else if (launch)                 first_pend <= 1'b0;
    else if (en_rise)                first_pend <= 1'b1;
    else if (ctrl_wr && !w_en)       first_pend <= 1'b0;
  end

  // completion wins over any clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (cpl_ok)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= '0; chan_sel <= '0; ref_sel <= '0;
    end else begin
      if (mux_wr) mux_q <= mux_t'(mux_wdata);
      if (!busy || cpl_ok) begin
        chan_sel <= mux_next.chan;
        ref_sel  <= mux_next.refsel;
      end
    end
  end

  assign ctrl_rdata = {psc_q, ie_q, flag_q, fr_q, busy, en_q};
  assign mux_rdata  = mux_q;
  assign irq        = flag_q && ie_q && gie;

  p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cpl_ok));
  p_start_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(ctrl_wr) && $past(ctrl_wdata[B_EN])
     && !$past(cpl_ok)) |-> busy);
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> (!busy && !$rose(flag_q)));
  p_mux_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(cpl_ok)) |-> ($stable(chan_sel) && $stable(ref_sel)));
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       mux_wr = 1'b0;
  logic [5:0] mux_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic [5:0] mux_rdata;
  logic       cmp_hi;
  logic [9:0] dac_code;
  logic       sample_en;
  logic [3:0] chan_sel;
  logic [1:0] ref_sel;
  logic [9:0] result;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic [9:0] vin = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  // analog model: comparator against the trial code
  assign cmp_hi = (vin >= dac_code);

  adc_seq_top dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .mux_wr(mux_wr), .mux_wdata(mux_wdata), .ctrl_rdata(ctrl_rdata),
    .mux_rdata(mux_rdata), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .sample_en(sample_en), .chan_sel(chan_sel), .ref_sel(ref_sel),
    .result(result), .gie(gie), .irq_ack(irq_ack), .irq(irq)
  );

  function automatic int ratio(input int sel);
    case (sel)
      0, 1: return 2;
      2: return 4;
      3: return 8;
      4: return 16;
      5: return 32;
      6: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(posedge clk);
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_mux(input logic [5:0] v);
    @(negedge clk); mux_wr = 1'b1; mux_wdata = v;
    @(posedge clk);
    @(negedge clk); mux_wr = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 6000; i++) begin
      if (ctrl_rdata[3]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d;
    logic [9:0] keep;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(ctrl_rdata == 8'h00, "R11 ctrl", ctrl_rdata, 0);
    check(mux_rdata == 6'h00, "R11 mux", mux_rdata, 0);
    check({irq, chan_sel, ref_sel} == 7'd0, "R11 outputs", {irq, chan_sel, ref_sel}, 0);
    check(result == 10'd0, "R11 result", result, 0);

    // R1 R2 R3 over every divider code
    for (int s = 0; s < 8; s++) begin
      d = ratio(s);
      vin = 10'(100 + s * 97);
      wr_ctrl({3'(s), 5'b00011});
      wait_edges(25 * d - 1);
      check(ctrl_rdata[3:1] == 3'b001, "R3 R1 first still busy", ctrl_rdata[3:1], 1);
      wait_edges(1);
      check(ctrl_rdata[3:1] == 3'b100, "R3 R1 first done", ctrl_rdata[3:1], 4);
      check(result == vin, "R5 result", result, vin);
      wr_ctrl({3'(s), 5'b01001});
      check(ctrl_rdata[3] == 1'b0, "R9 clear by one", ctrl_rdata[3], 0);
      wr_ctrl({3'(s), 5'b00011});
      wait_edges(13 * d - 1);
      check(ctrl_rdata[3:1] == 3'b001, "R2 R1 still busy", ctrl_rdata[3:1], 1);
      wait_edges(1);
      check(ctrl_rdata[3:1] == 3'b100, "R2 R1 done", ctrl_rdata[3:1], 4);
      wr_ctrl({3'(s), 5'b01000});
    end

    // R3 enable first, start later
    wr_ctrl(8'h01);
    wr_ctrl(8'h03);
    wait_edges(49);
    check(ctrl_rdata[1] == 1'b1, "R3 separate start busy", ctrl_rdata[1], 1);
    wait_edges(1);
    check(ctrl_rdata[3:1] == 3'b100, "R3 separate start done", ctrl_rdata[3:1], 4);

    // R5 sample phase and first trial code
    vin = 10'h2AA;
    wr_ctrl(8'h0B);
    check(sample_en == 1'b1, "R5 sample phase", sample_en, 1);
    wait_edges(2);
    check(sample_en == 1'b0 && dac_code == 10'h200, "R5 msb trial", dac_code, 10'h200);
    wait_flag();
    check(result == 10'h2AA, "R5 pattern", result, 10'h2AA);

    // R5 exhaustive comparator sweep
    for (int v = 0; v < 1024; v++) begin
      vin = 10'(v);
      wr_ctrl(8'h0B);
      wait_flag();
      check(result == 10'(v), "R5 sweep", result, v);
    end

    // R4 start semantics
    wr_ctrl(8'h0B);
    check(ctrl_rdata[1] == 1'b1, "R4 busy reads one", ctrl_rdata[1], 1);
    wait_edges(3);
    wr_ctrl(8'h01);
    check(ctrl_rdata[1] == 1'b1, "R4 zero write no effect", ctrl_rdata[1], 1);
    wait_flag();
    check(ctrl_rdata[1] == 1'b0, "R4 busy clears", ctrl_rdata[1], 0);
    wr_ctrl(8'h08);
    wr_ctrl(8'h02);
    wait_edges(40);
    check(ctrl_rdata[3:1] == 3'b000, "R4 start while disabled", ctrl_rdata[3:1], 0);

    // R7 abort
    keep = result;
    vin = 10'd500;
    wr_ctrl(8'h03);
    wait_edges(10);
    wr_ctrl(8'h00);
    check(ctrl_rdata[1] == 1'b0, "R7 abort stops", ctrl_rdata[1], 0);
    wait_edges(80);
    check(ctrl_rdata[3] == 1'b0, "R7 no flag", ctrl_rdata[3], 0);
    check(result == keep, "R7 no result", result, keep);

    // R6 continuous mode
    wr_ctrl(8'h01);
    vin = 10'd300;
    wr_ctrl(8'h07);
    wait_flag();
    check(result == 10'd300, "R6 first result", result, 300);
    vin = 10'd700;
    wr_ctrl(8'h0D);
    check(ctrl_rdata[1] == 1'b1, "R6 continues", ctrl_rdata[1], 1);
    wait_edges(23);
    check(ctrl_rdata[3] == 1'b0, "R6 spacing early", ctrl_rdata[3], 0);
    wait_edges(1);
    check(ctrl_rdata[3:1] == 3'b111, "R6 back to back", ctrl_rdata[3:1], 7);
    check(result == 10'd700, "R6 second result", result, 700);
    wr_ctrl(8'h09);
    wait_flag();
    wait_edges(60);
    check(ctrl_rdata[1] == 1'b0, "R6 stops after clear", ctrl_rdata[1], 0);

    // R8 deferred channel and reference
    wr_mux(6'h13);
    check(chan_sel == 4'd3 && ref_sel == 2'd1, "R8 idle update", chan_sel, 3);
    wr_ctrl(8'h0B);
    wait_edges(5);
    wr_mux(6'h35);
    check(mux_rdata == 6'h35, "R8 readback", mux_rdata, 6'h35);
    check(chan_sel == 4'd3 && ref_sel == 2'd1, "R8 held", chan_sel, 3);
    wait_edges(18);
    check(chan_sel == 4'd3, "R8 held at last clock", chan_sel, 3);
    wait_edges(1);
    check(chan_sel == 4'd5 && ref_sel == 2'd3, "R8 applied at completion", {ref_sel, chan_sel}, 8'h35);
    wr_mux(6'h0F);
    check(chan_sel == 4'd15 && ref_sel == 2'd0, "R8 ground code", chan_sel, 15);

    // R9 R10 flag and interrupt
    wr_ctrl(8'h01);
    check(ctrl_rdata[3] == 1'b1, "R9 zero keeps flag", ctrl_rdata[3], 1);
    check(irq == 1'b0, "R10 ie low", irq, 0);
    wr_ctrl(8'h11);
    check(irq == 1'b0, "R10 gie low", irq, 0);
    gie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 all high", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check(ctrl_rdata[3] == 1'b0 && irq == 1'b0, "R9 ack clears", ctrl_rdata[3], 0);
    wr_ctrl(8'h13);
    wait_edges(24);
    wr_ctrl(8'h19);
    check(ctrl_rdata[3] == 1'b1 && irq == 1'b1, "R9 set beats clear", ctrl_rdata[3], 1);
    wr_ctrl(8'h19);
    check(ctrl_rdata[3] == 1'b0, "R9 later clear", ctrl_rdata[3], 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule